// File: doc/BRIEF.md
# Multi-channel general purpose timer

A bank of independent count channels behind a small memory-mapped register port. Each channel owns a control word, a clock-configuration word, a live count and a compare value. A channel advances by one on every cycle where it is enabled and its tick enable input is high. The tick enables come from a separate prescaler, which is driven by the clock-configuration words the bank exports. When the count reaches the compare value, the channel sets its flag in a shared status register. A shared enable mask picks which flags drive the single interrupt output. Software clears flags by writing ones to a shared acknowledge register.

Each channel runs in one of four count modes. Single-shot stops itself after one match. Repeat returns to zero on each match. Keep-going flags the match and counts on past it. Free-running wraps at the top of the count width and never flags. The register port is a plain control interface: a write happens in the cycle the strobe is high, and read data is combinational from the address. No stream handshake or back-pressure applies.

Top module: `gp_timer_bank`

## Requirements
- R1: After reset every readable register returns 0 and `irq` is low.
- R2: Registers are 32-bit words; byte addresses with bits 1:0 nonzero are not decoded and read 0. The shared interrupt enable mask is at 0x00, the status at 0x04 and the acknowledge at 0x08. Channel n (1..5) has its control word at 0x10·n, its clock word at 0x10·n+4, its count at 0x10·n+8 and its compare at 0x10·n+0xC. The clock word keeps bits 4:0, reads them back and drives `clk_sel[5n-1:5n-5]`.
- R3: Single-shot mode (control bits 5:4 = 0): the count climbs to the compare value, sets status bit n-1 there, clears control bit 0 and then holds.
- R4: Repeat mode (bits 5:4 = 1): when the incremented count equals compare, the count becomes 0 and the flag is set. After k ticks the count is k mod compare.
- R5: Keep-going mode (bits 5:4 = 2): the flag is set when the count reaches compare, and counting continues past it.
- R6: Free-running mode (bits 5:4 = 3): the count advances on every tick and never sets a flag, even when it passes the compare value.
- R7: Control bit 1 is a self-clearing counter clear that always reads 0. A write with bits 0 and 1 set restarts the count from 0 with the newly written mode.
- R8: With control bit 0 clear, a channel neither counts nor sets its flag.
- R9: `irq` is the OR over channels of (status AND enable mask). Status bits are set whatever the mask holds.
- R10: Writing ones to the acknowledge register clears those status bits. If a match and an acknowledge of the same bit fall in one cycle, the bit ends set.
- R11: Writes to the count and status registers have no effect.
- R12: An enabled channel advances only in cycles where its bit of `tick_en` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 8 | Byte address of the register access |
| reg_wdata | input | 32 | Write data |
| reg_we | input | 1 | Write strobe, one write per high cycle |
| reg_rdata | output | 32 | Combinational read data for `reg_addr` |
| tick_en | input | 5 | Per-channel count enable from the prescaler, bit n-1 for channel n |
| clk_sel | output | 25 | Clock word of each channel, 5 bits per channel |
| irq | output | 1 | Combined interrupt |

## Verification
The assertions assume that `tick_en` and the register inputs change only between clock edges. They also assume that a control write which lands in a tick cycle takes that cycle, so the channel does not count then. They further assume that compare values are nonzero whenever a match is expected. The bench keeps to these rules. It drives every input on the falling edge and holds all tick enables low while it writes configuration. It then pulses ticks for one chosen channel only, picks compare values from 1 to 20, and draws the tick count and mode at random from a fixed seed. Directed cases cover the same-cycle set and acknowledge, disabling a channel, and the read-only registers.

// File: rtl/gpt_pkg.sv
package gpt_pkg;
  typedef enum logic [1:0] {
    MODE_ONCE   = 2'd0,
    MODE_REPEAT = 2'd1,
    MODE_KEEP   = 2'd2,
    MODE_FREE   = 2'd3
  } gpt_mode_e;

  // word index inside a 16-byte register group
  localparam logic [1:0] SUB_CTRL = 2'd0;
  localparam logic [1:0] SUB_CLK  = 2'd1;
  localparam logic [1:0] SUB_CNT  = 2'd2;
  localparam logic [1:0] SUB_CMP  = 2'd3;

  localparam logic [1:0] SUB_IEN  = 2'd0;
  localparam logic [1:0] SUB_IST  = 2'd1;
  localparam logic [1:0] SUB_IACK = 2'd2;

  localparam int CTRL_EN_BIT  = 0;
  localparam int CTRL_CLR_BIT = 1;
  localparam int CTRL_MODE_LO = 4;
endpackage

// File: rtl/gpt_channel.sv
module gpt_channel
  import gpt_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int CLK_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctrl_we,
  input  logic             clk_we,
  input  logic             cmp_we,
  input  logic [CNT_W-1:0] wdata,
  input  logic             tick,
  output logic             en_o,
  output gpt_mode_e        mode_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] cmp_o,
  output logic [CLK_W-1:0] clk_cfg_o,
  output logic             match_o
);
  logic             en_q;
  gpt_mode_e        mode_q;
  logic [CNT_W-1:0] cnt_q, cmp_q, cnt_inc;
  logic [CLK_W-1:0] clk_q;
  logic             step, hit;

  assign cnt_inc = cnt_q + 1'b1;
  assign step    = tick && en_q && !ctrl_we;
  assign hit     = step && (cnt_inc == cmp_q) && (mode_q != MODE_FREE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      mode_q <= MODE_ONCE;
      cnt_q  <= '0;
      cmp_q  <= '0;
      clk_q  <= '0;
    end else begin
      if (cmp_we) cmp_q <= wdata;
      if (clk_we) clk_q <= wdata[CLK_W-1:0];
      if (ctrl_we) begin
        en_q   <= wdata[CTRL_EN_BIT];
        mode_q <= gpt_mode_e'(wdata[CTRL_MODE_LO+1:CTRL_MODE_LO]);
        if (wdata[CTRL_CLR_BIT]) cnt_q <= '0;
      end else if (step) begin
        if (hit && mode_q == MODE_REPEAT) cnt_q <= '0;
        else cnt_q <= cnt_inc;
        if (hit && mode_q == MODE_ONCE) en_q <= 1'b0;
      end
    end
  end

  assign en_o      = en_q;
  assign mode_o    = mode_q;
  assign cnt_o     = cnt_q;
  assign cmp_o     = cmp_q;
  assign clk_cfg_o = clk_q;
  assign match_o   = hit;

  p_oneshot_stop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (match_o && mode_q == MODE_ONCE) |=> !en_q);
  p_repeat_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (match_o && mode_q == MODE_REPEAT) |=> (cnt_q == '0));
  p_clear_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_we && wdata[CTRL_CLR_BIT]) |=> (cnt_q == '0));
  p_disabled_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !ctrl_we) |=> $stable(cnt_q));
  p_no_tick_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !ctrl_we) |=> $stable(cnt_q));
  p_free_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_FREE && !ctrl_we) |=> !$past(match_o));
endmodule

// File: rtl/gpt_irq_bank.sv
module gpt_irq_bank #(
  parameter int NCH = 5
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           en_we,
  input  logic           ack_we,
  input  logic [NCH-1:0] wdata,
  input  logic [NCH-1:0] match,
  output logic [NCH-1:0] en_o,
  output logic [NCH-1:0] st_o,
  output logic           irq
);
  logic [NCH-1:0] en_q, st_q, ack_mask;

  assign ack_mask = ack_we ? wdata : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q <= '0;
      st_q <= '0;
    end else begin
      if (en_we) en_q <= wdata;
      st_q <= (st_q & ~ack_mask) | match;
    end
  end

  assign en_o = en_q;
  assign st_o = st_q;
  assign irq  = |(st_q & en_q);

  p_set_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (match != '0) |=> ((st_q & $past(match)) == $past(match)));
  p_ack_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_we && match == '0) |=> ((st_q & $past(wdata)) == '0));
  p_st_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!ack_we && match == '0) |=> $stable(st_q));
endmodule

// File: rtl/gp_timer_bank.sv
module gp_timer_bank
  import gpt_pkg::*;
#(
  parameter int NUM_CH = 5,
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 8,
  parameter int CLK_W  = 5
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [ADDR_W-1:0]       reg_addr,
  input  logic [CNT_W-1:0]        reg_wdata,
  input  logic                    reg_we,
  output logic [CNT_W-1:0]        reg_rdata,
  input  logic [NUM_CH-1:0]       tick_en,
  output logic [NUM_CH*CLK_W-1:0] clk_sel,
  output logic                    irq
);
  localparam int IDX_W = ADDR_W - 4;

  logic [IDX_W-1:0] grp;
  logic [1:0]       sub;
  logic             aligned;

  assign grp     = reg_addr[ADDR_W-1:4];
  assign sub     = reg_addr[3:2];
  assign aligned = (reg_addr[1:0] == 2'b00);

  logic [NUM_CH-1:0]            en_v, match_v, ien, ist;
  gpt_mode_e                    mode_v [NUM_CH];
  logic [NUM_CH-1:0][CNT_W-1:0] cnt_v, cmp_v;
  logic [NUM_CH-1:0][CLK_W-1:0] clk_v;

  logic glob_we;
  assign glob_we = reg_we && aligned && (grp == '0);

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic ch_we;
    assign ch_we = reg_we && aligned && (grp == IDX_W'(i + 1));

    gpt_channel #(.CNT_W(CNT_W), .CLK_W(CLK_W)) u_ch (
      .clk       (clk),
      .rst_n     (rst_n),
      .ctrl_we   (ch_we && sub == SUB_CTRL),
      .clk_we    (ch_we && sub == SUB_CLK),
      .cmp_we    (ch_we && sub == SUB_CMP),
      .wdata     (reg_wdata),
      .tick      (tick_en[i]),
      .en_o      (en_v[i]),
      .mode_o    (mode_v[i]),
      .cnt_o     (cnt_v[i]),
      .cmp_o     (cmp_v[i]),
      .clk_cfg_o (clk_v[i]),
      .match_o   (match_v[i])
    );
  end

  gpt_irq_bank #(.NCH(NUM_CH)) u_irq (
    .clk    (clk),
    .rst_n  (rst_n),
    .en_we  (glob_we && sub == SUB_IEN),
    .ack_we (glob_we && sub == SUB_IACK),
    .wdata  (reg_wdata[NUM_CH-1:0]),
    .match  (match_v),
    .en_o   (ien),
    .st_o   (ist),
    .irq    (irq)
  );

  assign clk_sel = clk_v;

  always_comb begin
    reg_rdata = '0;
    if (aligned) begin
      if (grp == '0) begin
        case (sub)
          SUB_IEN: reg_rdata[NUM_CH-1:0] = ien;
          SUB_IST: reg_rdata[NUM_CH-1:0] = ist;
          default: reg_rdata = '0;
        endcase
      end
      for (int i = 0; i < NUM_CH; i++) begin
        if (grp == IDX_W'(i + 1)) begin
          case (sub)
            SUB_CTRL: begin
              reg_rdata[CTRL_EN_BIT] = en_v[i];
              reg_rdata[CTRL_MODE_LO+1:CTRL_MODE_LO] = mode_v[i];
            end
            SUB_CLK: reg_rdata[CLK_W-1:0] = clk_v[i];
            SUB_CNT: reg_rdata = cnt_v[i];
            default: reg_rdata = cmp_v[i];
          endcase
        end
      end
    end
  end

  p_irq_needs_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (ist != '0));
endmodule

// File: tb/gp_timer_bank_test.sv
module gp_timer_bank_test;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic        reg_we = 1'b0;
  logic [31:0] reg_rdata;
  logic [NCH-1:0] tick_en = '0;
  logic [NCH*5-1:0] clk_sel;
  logic        irq;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gp_timer_bank uut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_we(reg_we), .reg_rdata(reg_rdata), .tick_en(tick_en),
    .clk_sel(clk_sel), .irq(irq)
  );

  function automatic logic [7:0] ch_addr(int ch, int sub);
    return 8'(16 * ch + 4 * sub);
  endfunction

  function automatic int exp_cnt(int mode, int cmp, int n);
    case (mode)
      0: return (n >= cmp) ? cmp : n;
      1: return n % cmp;
      default: return n;
    endcase
  endfunction

  function automatic int exp_flag(int mode, int cmp, int n);
    if (mode == 3) return 0;
    return (n >= cmp) ? 1 : 0;
  endfunction

  function automatic int exp_en(int mode, int cmp, int n);
    return (mode == 0 && n >= cmp) ? 0 : 1;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic ticks(int ch, int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      tick_en = NCH'(1 << (ch - 1));
    end
    @(negedge clk);
    tick_en = '0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int seed;
    seed = $urandom(2024);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset values
    for (int ch = 1; ch <= NCH; ch++) begin
      for (int s = 0; s < 4; s++) begin
        rd(ch_addr(ch, s), v);
        check("R1 channel reg", v, 0);
      end
    end
    rd(8'h00, v); check("R1 enable", v, 0);
    rd(8'h04, v); check("R1 status", v, 0);
    check("R1 irq", {31'b0, irq}, 0);

    // R2: clock word readback and export, misaligned read
    wr(ch_addr(3, 1), 32'hFFFF_FFF5);
    rd(ch_addr(3, 1), v); check("R2 clock readback", v, 32'h15);
    check("R2 clk_sel slice", {27'b0, clk_sel[14:10]}, 32'h15);
    wr(ch_addr(2, 3), 32'h1234);
    rd(ch_addr(2, 3) + 8'd1, v); check("R2 misaligned reads 0", v, 0);
    rd(ch_addr(2, 3), v); check("R2 compare readback", v, 32'h1234);

    // R11: count and status are read-only
    wr(ch_addr(2, 2), 32'hDEAD);
    rd(ch_addr(2, 2), v); check("R11 count write ignored", v, 0);
    wr(8'h04, 32'h1F);
    rd(8'h04, v); check("R11 status write ignored", v, 0);

    // R10: set wins over acknowledge in the same cycle
    wr(ch_addr(4, 3), 3);
    wr(ch_addr(4, 0), 32'h23);          // keep-going, enable+clear
    ticks(4, 2);
    @(negedge clk);
    reg_addr = 8'h08; reg_wdata = 32'h08; reg_we = 1'b1; tick_en = 5'b01000;
    @(negedge clk);
    reg_we = 1'b0; tick_en = '0;
    rd(8'h04, v); check("R10 set wins", v, 32'h08);
    wr(8'h08, 32'h3F);
    rd(8'h04, v); check("R10 ack clears", v, 0);

    // R5: counted past compare
    rd(ch_addr(4, 2), v); check("R5 keep counting", v, 3);
    ticks(4, 4);
    rd(ch_addr(4, 2), v); check("R5 past compare", v, 7);

    // R8: disable stops counting and flags
    wr(ch_addr(4, 0), 32'h20);
    ticks(4, 6);
    rd(ch_addr(4, 2), v); check("R8 count frozen", v, 7);
    rd(8'h04, v); check("R8 no flag", v, 0);

    // R7: clear reads 0 and restarts
    wr(ch_addr(4, 0), 32'h13);          // repeat, enable+clear
    rd(ch_addr(4, 0), v); check("R7 clear reads 0", v, 32'h11);
    rd(ch_addr(4, 2), v); check("R7 count restarted", v, 0);

    // R12: enabled but no tick
    repeat (5) @(negedge clk);
    rd(ch_addr(4, 2), v); check("R12 no tick no count", v, 0);

    // R9: masked flag, then unmasked
    wr(8'h00, 0);
    wr(ch_addr(1, 3), 2);
    wr(ch_addr(1, 0), 32'h03);
    ticks(1, 2);
    rd(8'h04, v); check("R9 status set while masked", v, 1);
    check("R9 irq masked", {31'b0, irq}, 0);
    wr(8'h00, 1);
    check("R9 irq unmasked", {31'b0, irq}, 1);
    wr(8'h08, 32'h3F);
    check("R9 irq after ack", {31'b0, irq}, 0);

    // R3 R4 R5 R6: random trials against the mode model
    for (int t = 0; t < 40; t++) begin
      int ch, mode, cmp, n, mask, fl;
      ch   = 1 + int'($urandom_range(NCH - 1));
      mode = int'($urandom_range(3));
      cmp  = 1 + int'($urandom_range(19));
      n    = int'($urandom_range(40));
      mask = int'($urandom_range(31));
      wr(8'h08, 32'h3F);
      wr(8'h00, 32'(mask));
      wr(ch_addr(ch, 3), 32'(cmp));
      wr(ch_addr(ch, 0), 32'((mode << 4) | 3));
      ticks(ch, n);
      fl = exp_flag(mode, cmp, n);
      rd(ch_addr(ch, 2), v);
      check(mode == 0 ? "R3 count" : mode == 1 ? "R4 count" :
            mode == 2 ? "R5 count" : "R6 count", v, 32'(exp_cnt(mode, cmp, n)));
      rd(8'h04, v);
      check(mode == 3 ? "R6 no flag" : "R3 R4 R5 flag", v, 32'(fl << (ch - 1)));
      rd(ch_addr(ch, 0), v);
      check("R3 enable state", v, 32'((mode << 4) | exp_en(mode, cmp, n)));
      check("R9 irq", {31'b0, irq}, 32'(fl & ((mask >> (ch - 1)) & 1)));
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule